// File: doc/BRIEF.md
# Third-Order Sinc Decimator with Programmable Phase Delay

This block takes the one-bit output of a delta-sigma modulator and turns it into signed 24-bit samples. It uses a three-stage cascaded integrator-comb filter that decimates by 128. The modulator bit arrives with a strobe, nominally once every eight system clocks. One filtered word therefore leaves once every 1024 system clocks, marked by a single-cycle valid pulse.

Phase alignment is built into the decimation path itself. This lets a current channel be lined up in time with its voltage channel. A fine delay of 0 to 511 modulator samples delays the bitstream before it enters the integrators. A coarse delay of 0 to 3 whole output words delays the decimated result before it is registered. An instance built for a voltage channel leaves out the fine stage and responds to the coarse setting only. Both settings are captured at output boundaries, so a change never splits the filter window.

Top module: `sinc3_phase_decim`

## Requirements
- R1: Input bit 1 counts as +1 and bit 0 as -1. When the input density holds steady, the settled output equals the mean input value times 2^21. For example, an 8-bit pattern with k ones repeated gives (2k-8)*2^18.
- R2: Exactly one output word is produced for every 128 accepted input bits. `smp_vld` is a one-cycle pulse on the clock after the 128th strobe, so valid pulses are 1024 clocks apart when strobes come every 8 clocks.
- R3: `smp_out` is a two's-complement 24-bit word and stays within +/-2^21. All ones gives exactly +2097152 and all zeros gives exactly -2097152.
- R4: While `rst` is high, `smp_vld` is 0, `smp_out` is 0 and `smp_settled` is 0. The delay inputs present during reset are the ones in force when reset is released.
- R5: A fine setting f (0..511) delays the bitstream by f modulator samples. With f = 128, the settled output sequence equals the undelayed sequence shifted by one word.
- R6: A coarse setting c (0..3) delays the output sequence by exactly c words. When both are set, the shifts add: coarse 3 with fine 256 gives a shift of 5 words.
- R7: Both delay settings are captured at each output event and govern the next output event. A coarse change made after output k is seen first at output k+2.
- R8: With the parameter `FINE_EN` = 0 (voltage channel), the fine setting has no effect on the output.
- R9: `smp_settled` is low on the first three outputs after reset and high on every later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe marking a new modulator bit |
| bit_in | input | 1 | Modulator bit, 1 = +1, 0 = -1 |
| coarse_dly | input | 2 | Output-word delay, 0..3 |
| fine_dly | input | 9 | Modulator-sample delay, 0..511 (ignored when FINE_EN = 0) |
| smp_out | output | 24 | Decimated signed sample, held between pulses |
| smp_vld | output | 1 | One-cycle pulse when `smp_out` is updated |
| smp_settled | output | 1 | High once the filter history is fully populated |

## Verification
The hardest condition to reach is a setting change that lands exactly between two output events. Its effect shows only as a repeated word two outputs later. The bench watches the valid count while it drives the stream and raises the coarse setting right after a chosen output. It then compares the following words against an undelayed run of the same pseudo-random stream. The phase shifts are proven the same way, against that reference run: whole-word delays, a 128-sample fine delay, and a combined coarse-plus-fine delay each must reproduce the reference shifted by the programmed number of words.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
    localparam int DEC_LOG2   = 7;
    localparam int DEC_RATIO  = 1 << DEC_LOG2;
    localparam int OUT_W      = 24;
    localparam int FINE_W     = 9;
    localparam int COARSE_W   = 2;
    localparam int ACC_W      = 3 * DEC_LOG2 + 2;
    localparam int EXT_W      = OUT_W - ACC_W;
    localparam int FINE_DEPTH = 1 << FINE_W;
    localparam int HIST_DEPTH = (1 << COARSE_W) - 1;
    localparam int FULL_SCALE = 1 << (3 * DEC_LOG2);

    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } dly_cfg_t;

    function automatic acc_t bit_to_step(input logic b);
        return b ? acc_t'(1) : -acc_t'(1);
    endfunction

    function automatic logic [OUT_W-1:0] widen(input acc_t v);
        return {{EXT_W{v[ACC_W-1]}}, v};
    endfunction
endpackage

// File: rtl/sinc3_fine_delay.sv
module sinc3_fine_delay
    import sinc3_pkg::*;
#(
    parameter bit EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic [FINE_W-1:0] tap,
    output logic              bit_out
);
    generate
        if (EN) begin : g_line
            logic [FINE_DEPTH-1:0] line_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    line_q <= '0;
                end else if (bit_vld) begin
                    line_q <= {line_q[FINE_DEPTH-2:0], bit_in};
                end
            end

            always_comb begin
                if (tap == '0) bit_out = bit_in;
                else           bit_out = line_q[tap - 1'b1];
            end
        end else begin : g_pass
            logic unused_ok;
            assign unused_ok = clk ^ rst ^ bit_vld ^ (^tap);
            assign bit_out   = bit_in;
        end
    endgenerate
endmodule

// File: rtl/sinc3_cic_core.sv
module sinc3_cic_core
    import sinc3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic evt,
    output acc_t y
);
    acc_t integ1_q, integ2_q, integ3_q;
    acc_t comb_d1_q, comb_d2_q, comb_d3_q;
    acc_t diff1, diff2;
    logic [DEC_LOG2-1:0] phase_q;

    assign evt   = bit_vld && (phase_q == DEC_LOG2'(DEC_RATIO - 1));
    assign diff1 = integ3_q - comb_d1_q;
    assign diff2 = diff1 - comb_d2_q;
    assign y     = diff2 - comb_d3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            integ1_q  <= '0;
            integ2_q  <= '0;
            integ3_q  <= '0;
            comb_d1_q <= '0;
            comb_d2_q <= '0;
            comb_d3_q <= '0;
            phase_q   <= '0;
        end else if (bit_vld) begin
            integ1_q <= integ1_q + bit_to_step(bit_in);
            integ2_q <= integ2_q + integ1_q;
            integ3_q <= integ3_q + integ2_q;
            phase_q  <= phase_q + 1'b1;
            if (evt) begin
                comb_d1_q <= integ3_q;
                comb_d2_q <= diff1;
                comb_d3_q <= diff2;
            end
        end
    end

    p_comb_range_r3: assert property (@(posedge clk) disable iff (rst)
        evt |-> (y <= acc_t'(FULL_SCALE)) && (y >= -acc_t'(FULL_SCALE)));
endmodule

// File: rtl/sinc3_coarse_delay.sv
module sinc3_coarse_delay
    import sinc3_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                evt,
    input  logic [COARSE_W-1:0] sel,
    input  acc_t                din,
    output acc_t                dout
);
    acc_t hist_q [HIST_DEPTH];

    always_ff @(posedge clk) begin
        if (rst)      hist_q[0] <= '0;
        else if (evt) hist_q[0] <= din;
    end

    generate
        for (genvar k = 1; k < HIST_DEPTH; k++) begin : g_hist
            always_ff @(posedge clk) begin
                if (rst)      hist_q[k] <= '0;
                else if (evt) hist_q[k] <= hist_q[k-1];
            end
        end
    endgenerate

    always_comb begin
        if (sel == '0) dout = din;
        else           dout = hist_q[sel - 1'b1];
    end
endmodule

// File: rtl/sinc3_phase_decim.sv
module sinc3_phase_decim
    import sinc3_pkg::*;
#(
    parameter bit FINE_EN = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_vld,
    input  logic                bit_in,
    input  logic [COARSE_W-1:0] coarse_dly,
    input  logic [FINE_W-1:0]   fine_dly,
    output logic [OUT_W-1:0]    smp_out,
    output logic                smp_vld,
    output logic                smp_settled
);
    dly_cfg_t cfg_q;
    logic     shifted_bit;
    logic     evt;
    acc_t     filt_y;
    acc_t     aligned_y;
    logic [1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst || evt) begin
            cfg_q.coarse <= coarse_dly;
            cfg_q.fine   <= fine_dly;
        end
    end

    sinc3_fine_delay #(.EN(FINE_EN)) u_fine (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .tap     (cfg_q.fine),
        .bit_out (shifted_bit)
    );

    sinc3_cic_core u_cic (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (bit_vld),
        .bit_in  (shifted_bit),
        .evt     (evt),
        .y       (filt_y)
    );

    sinc3_coarse_delay u_coarse (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .sel  (cfg_q.coarse),
        .din  (filt_y),
        .dout (aligned_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_out     <= '0;
            smp_vld     <= 1'b0;
            smp_settled <= 1'b0;
            seen_q      <= '0;
        end else begin
            smp_vld <= evt;
            if (evt) begin
                smp_out     <= widen(aligned_y);
                smp_settled <= (seen_q == 2'd3);
                if (seen_q != 2'd3) seen_q <= seen_q + 1'b1;
            end
        end
    end

    p_vld_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> !smp_vld);
    p_vld_after_bit_r2: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> $past(bit_vld));
    p_reset_clear_r4: assert property (@(posedge clk)
        rst |=> (!smp_vld && smp_out == '0 && !smp_settled));
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(cfg_q));
    p_settle_only_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(smp_settled) |-> $past(rst));
endmodule

// File: tb/tb_sinc3_phase_decim.sv
module tb_sinc3_phase_decim;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic [1:0]  coarse_dly = '0;
    logic [8:0]  fine_dly = '0;
    logic [23:0] smp_out, v_out;
    logic        smp_vld, smp_settled, v_vld, v_settled;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int idx = 0;
    bit done = 1'b0;

    logic signed [23:0] res  [0:15];
    logic signed [23:0] resv [0:15];
    logic signed [23:0] ref_a[0:15];
    logic               stl  [0:15];
    int                 vcyc [0:15];

    // {pattern, expected settled word}
    localparam logic [39:0] DC_TAB [0:6] = '{
        {8'hFF, 32'h0020_0000}, {8'h00, 32'hFFE0_0000}, {8'h55, 32'h0000_0000},
        {8'h01, 32'hFFE8_0000}, {8'h7F, 32'h0018_0000}, {8'h0F, 32'h0000_0000},
        {8'h07, 32'hFFF8_0000}};

    always #2.5 clk = ~clk;

    sinc3_phase_decim #(.FINE_EN(1'b1)) dut (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .coarse_dly(coarse_dly), .fine_dly(fine_dly),
        .smp_out(smp_out), .smp_vld(smp_vld), .smp_settled(smp_settled));

    sinc3_phase_decim #(.FINE_EN(1'b0)) dut_v (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .coarse_dly(coarse_dly), .fine_dly(fine_dly),
        .smp_out(v_out), .smp_vld(v_vld), .smp_settled(v_settled));

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst) idx = 0;
        else if (smp_vld) begin
            if (idx < 16) begin
                res[idx] = smp_out; resv[idx] = v_out;
                stl[idx] = smp_settled; vcyc[idx] = cyc;
            end
            idx = idx + 1;
        end
    end

    always @(negedge clk) begin
        if (cyc > 195000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic prbs(input int j);
        logic [31:0] h;
        h = j * 32'h9E37_79B1;
        return ^h[31:20];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] pat, input bit use_prbs, input int c,
                       input int f, input int nout, input int chg_at);
        int j;
        coarse_dly = 2'(c); fine_dly = 9'(f); bit_vld = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        j = 0;
        while (idx < nout) begin
            @(negedge clk);
            bit_vld = 1'b1;
            bit_in  = use_prbs ? prbs(j) : pat[j % 8];
            @(negedge clk);
            bit_vld = 1'b0;
            repeat (6) @(negedge clk);
            j++;
            if (chg_at >= 0 && idx == chg_at + 1) coarse_dly = 2'(c + 1);
        end
    endtask

    initial begin
        // R4: reset state
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 vld", int'(smp_vld), 0);
        chk("R4 out", int'($signed(smp_out)), 0);
        chk("R4 settled", int'(smp_settled), 0);

        // R1, R3: steady-density table
        for (int t = 0; t < 7; t++) begin
            run(DC_TAB[t][39:32], 1'b0, 0, 0, 5, -1);
            chk($sformatf("R1 dc pattern %h", DC_TAB[t][39:32]),
                int'(res[4]), int'($signed(DC_TAB[t][31:0])));
        end

        // R3, R6, R5, R9: full scale with maximum delays
        run(8'hFF, 1'b0, 3, 511, 10, -1);
        chk("R3 full scale max delay", int'(res[9]), 2097152);
        chk("R9 output 2 unsettled", int'(stl[2]), 0);
        chk("R9 output 3 settled", int'(stl[3]), 1);
        chk("R9 output 9 settled", int'(stl[9]), 1);

        // reference run, no delay
        run(8'h00, 1'b1, 0, 0, 12, -1);
        for (int n = 0; n < 12; n++) ref_a[n] = res[n];
        chk("R2 output spacing", vcyc[5] - vcyc[4], 1024);

        // R6: one-word coarse delay
        run(8'h00, 1'b1, 1, 0, 12, -1);
        for (int n = 9; n < 12; n++) chk("R6 coarse 1", int'(res[n]), int'(ref_a[n-1]));

        // R5: fine 128 equals one word; R8: voltage instance ignores fine
        run(8'h00, 1'b1, 0, 128, 12, -1);
        for (int n = 9; n < 12; n++) chk("R5 fine 128", int'(res[n]), int'(ref_a[n-1]));
        for (int n = 4; n < 12; n++) chk("R8 fine ignored", int'(resv[n]), int'(ref_a[n]));

        // R6 with R5: combined coarse 3 and fine 256 -> 5 words
        run(8'h00, 1'b1, 3, 256, 12, -1);
        for (int n = 9; n < 12; n++) chk("R6 combined shift", int'(res[n]), int'(ref_a[n-5]));

        // R7: coarse change right after output 6
        run(8'h00, 1'b1, 0, 0, 12, 6);
        chk("R7 output 7 old setting", int'(res[7]), int'(ref_a[7]));
        chk("R7 output 8 new setting", int'(res[8]), int'(ref_a[7]));
        chk("R7 output 9 new setting", int'(res[9]), int'(ref_a[8]));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule